// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block holds the digital divider chain of an integer-N frequency synthesizer. A fast input clock passes through a dual-modulus prescaler, which divides by 2^PW or 2^PW+1 (64 or 65 by default). Each prescaler period clocks a main counter and a swallow counter. The prescaler uses the larger modulus while the swallow counter is non-zero, and the smaller one after that. One feedback period therefore spans 2^PW·N + A input cycles. The block gets unit-step resolution with no wide counter running at the full input rate.

A separate divider on the reference clock emits a comparison pulse every R reference cycles. The three settings N, A and R arrive on one programming port and are written with a single strobe. A written setting is checked before it is accepted. An accepted setting reaches each divider only at that divider's next period boundary, so no output period is ever cut short. The phase detector and the analog loop that use these two pulses sit outside the block.

Top module: `swallow_divider`

## Requirements
- R1: `fb_pulse` is high for exactly one `fin_clk` cycle per feedback period. The period is 2^PW·N + A `fin_clk` cycles, made of A prescaler periods of 2^PW+1 cycles followed by N−A periods of 2^PW cycles.
- R2: With the default parameters (modulus 64/65), N=77 and A=5 give a feedback period of 4933 `fin_clk` cycles.
- R3: `cmp_pulse` is high for exactly one `ref_clk` cycle out of every R `ref_clk` cycles. With the default widths, R=512 gives 512 cycles, which turns 7.68 MHz into 15 kHz.
- R4: A write whose A is not strictly less than its N is rejected and sets `prog_err`. The running ratio is unchanged.
- R5: A write with N below N_MIN (5) or R below R_MIN (5) is rejected, `prog_err` rises and the periods keep their previous lengths. `prog_err` only changes on a write: one cycle after `prog_load` it equals the inverse of the write's legality, and between writes it holds its value.
- R6: An accepted N/A write does not change the feedback period in progress. That period ends with the old length, and the following one has the new length.
- R7: An accepted R write reaches the reference divider through a synchronizer. Every reference period has the full old length or the full new length, and the second full period after the write has the new length. Writes must be spaced at least four `ref_clk` cycles apart.
- R8: During and after reset no pulse is pending and `prog_err` is low. The dividers start with N=RST_N, A=RST_A and R=RST_R, so the first feedback periods last 2^PW·RST_N+RST_A cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Fast input clock to be divided; also clocks the programming port |
| ref_clk | input | 1 | Reference clock for the comparison divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prog_n | input | NW | Main counter setting N |
| prog_a | input | AW | Swallow counter setting A |
| prog_r | input | RW | Reference divide ratio R |
| prog_load | input | 1 | One-cycle write strobe, sampled on `fin_clk` |
| fb_pulse | output | 1 | One-cycle feedback pulse per 2^PW·N+A input cycles |
| cmp_pulse | output | 1 | One-cycle comparison pulse per R reference cycles |
| prog_err | output | 1 | Set by a rejected write, cleared by an accepted one |

## Verification
The bench builds two copies of the block. The first is a reduced copy with a 4/5 prescaler, 5-bit N, 2-bit A and 5-bit R. Its periods are short, so every legal N/A pair and every legal R can be swept in turn, and the period that straddles each write can be measured. The second copy uses the default 64/65, 12/6/14-bit configuration. It covers the 4933-cycle and 512-cycle example settings, and the A≥N rejection, which the reduced copy cannot reach because its A never reaches N_MIN.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int PW    = 6,
  parameter int NW    = 12,
  parameter int AW    = 6,
  parameter int RW    = 14,
  parameter int N_MIN = 5,
  parameter int R_MIN = 5,
  parameter int RST_N = 5,
  parameter int RST_A = 0,
  parameter int RST_R = 5
) (
  input  logic          fin_clk,
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [NW-1:0] prog_n,
  input  logic [AW-1:0] prog_a,
  input  logic [RW-1:0] prog_r,
  input  logic          prog_load,
  output logic          fb_pulse,
  output logic          cmp_pulse,
  output logic          prog_err
);
  localparam int PCW = PW + 1;
  localparam logic [PCW-1:0] P_LO = PCW'((1 << PW) - 1);
  localparam logic [PCW-1:0] P_HI = PCW'(1 << PW);

  logic [NW-1:0]  pend_n, n_cnt;
  logic [AW-1:0]  pend_a, a_cnt;
  logic [RW-1:0]  pend_r, r_shadow, r_cnt;
  logic [PCW-1:0] p_cnt;
  logic           pend_tog, s1, s2, s3;

  wire legal = (prog_n >= NW'(N_MIN)) && (prog_r >= RW'(R_MIN)) && (NW'(prog_a) < prog_n);
  wire tick  = (p_cnt == '0);
  wire last  = tick && (n_cnt == NW'(1));
  wire [AW-1:0] a_dec = a_cnt - AW'(a_cnt != '0);

  always_ff @(posedge fin_clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_n   <= NW'(RST_N);
      pend_a   <= AW'(RST_A);
      pend_r   <= RW'(RST_R);
      pend_tog <= 1'b0;
      prog_err <= 1'b0;
    end else if (prog_load) begin
      prog_err <= !legal;
      if (legal) begin
        pend_n   <= prog_n;
        pend_a   <= prog_a;
        pend_r   <= prog_r;
        pend_tog <= ~pend_tog;
      end
    end
  end

  always_ff @(posedge fin_clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt    <= NW'(RST_N);
      a_cnt    <= AW'(RST_A);
      p_cnt    <= (RST_A != 0) ? P_HI : P_LO;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= last;
      if (last) begin
        n_cnt <= pend_n;
        a_cnt <= pend_a;
        p_cnt <= (pend_a != '0) ? P_HI : P_LO;
      end else if (tick) begin
        n_cnt <= n_cnt - NW'(1);
        a_cnt <= a_dec;
        p_cnt <= (a_dec != '0) ? P_HI : P_LO;
      end else begin
        p_cnt <= p_cnt - PCW'(1);
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      r_shadow  <= RW'(RST_R);
      r_cnt     <= RW'(RST_R);
      cmp_pulse <= 1'b0;
    end else begin
      s1 <= pend_tog;
      s2 <= s1;
      s3 <= s2;
      if (s2 != s3) r_shadow <= pend_r;
      cmp_pulse <= (r_cnt == RW'(1));
      r_cnt     <= (r_cnt == RW'(1)) ? r_shadow : r_cnt - RW'(1);
    end
  end
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int NW    = 12,
  parameter int AW    = 6,
  parameter int RW    = 14,
  parameter int N_MIN = 5,
  parameter int R_MIN = 5
) (
  input logic          fin_clk,
  input logic          ref_clk,
  input logic          rst_n,
  input logic          prog_load,
  input logic          prog_err,
  input logic          fb_pulse,
  input logic          cmp_pulse,
  input logic [NW-1:0] n_cnt,
  input logic [AW-1:0] a_cnt,
  input logic [NW-1:0] pend_n,
  input logic [AW-1:0] pend_a,
  input logic [RW-1:0] pend_r,
  input logic [RW-1:0] r_cnt
);
  a_r1_fb_single: assert property (@(posedge fin_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r3_cmp_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  a_r3_rcnt_live: assert property (@(posedge ref_clk) disable iff (!rst_n)
    r_cnt != '0);

  a_r4_swallow_below_main: assert property (@(posedge fin_clk) disable iff (!rst_n)
    NW'(a_cnt) < n_cnt);

  a_r4_pend_legal: assert property (@(posedge fin_clk) disable iff (!rst_n)
    (NW'(pend_a) < pend_n) && (pend_n >= NW'(N_MIN)) && (pend_r >= RW'(R_MIN)));

  a_r5_err_only_on_write: assert property (@(posedge fin_clk) disable iff (!rst_n)
    !$past(prog_load) |-> $stable(prog_err));
endmodule

bind swallow_divider swallow_divider_chk #(
  .NW(NW), .AW(AW), .RW(RW), .N_MIN(N_MIN), .R_MIN(R_MIN)
) u_chk (
  .fin_clk(fin_clk), .ref_clk(ref_clk), .rst_n(rst_n),
  .prog_load(prog_load), .prog_err(prog_err),
  .fb_pulse(fb_pulse), .cmp_pulse(cmp_pulse),
  .n_cnt(n_cnt), .a_cnt(a_cnt), .pend_n(pend_n), .pend_a(pend_a),
  .pend_r(pend_r), .r_cnt(r_cnt)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic fin_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  always #2.5 fin_clk = ~fin_clk;
  always #3.5 ref_clk = ~ref_clk;

  logic [4:0]  s_n = 5'd5;
  logic [1:0]  s_a = 2'd0;
  logic [4:0]  s_r = 5'd5;
  logic        s_ld = 1'b0;
  logic        s_fb, s_cmp, s_err;

  logic [11:0] b_n = 12'd5;
  logic [5:0]  b_a = 6'd0;
  logic [13:0] b_r = 14'd5;
  logic        b_ld = 1'b0;
  logic        b_fb, b_cmp, b_err;

  swallow_divider #(.PW(2), .NW(5), .AW(2), .RW(5)) u_dut (
    .fin_clk(fin_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .prog_n(s_n), .prog_a(s_a), .prog_r(s_r), .prog_load(s_ld),
    .fb_pulse(s_fb), .cmp_pulse(s_cmp), .prog_err(s_err));

  swallow_divider u_dut_full (
    .fin_clk(fin_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .prog_n(b_n), .prog_a(b_a), .prog_r(b_r), .prog_load(b_ld),
    .fb_pulse(b_fb), .cmp_pulse(b_cmp), .prog_err(b_err));

  int total = 0, bad = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic s_wait_fb(output int c);
    c = 0;
    do begin @(negedge fin_clk); c++; end while (!s_fb);
  endtask

  task automatic s_wait_cmp(output int c);
    c = 0;
    do begin @(negedge ref_clk); c++; end while (!s_cmp);
  endtask

  task automatic b_wait_fb(output int c);
    c = 0;
    do begin @(negedge fin_clk); c++; end while (!b_fb);
  endtask

  task automatic b_wait_cmp(output int c);
    c = 0;
    do begin @(negedge ref_clk); c++; end while (!b_cmp);
  endtask

  task automatic s_load(int n, int a, int r);
    s_n = 5'(n); s_a = 2'(a); s_r = 5'(r); s_ld = 1'b1;
    @(negedge fin_clk);
    s_ld = 1'b0;
  endtask

  task automatic b_load(int n, int a, int r);
    b_n = 12'(n); b_a = 6'(a); b_r = 14'(r); b_ld = 1'b1;
    @(negedge fin_clk);
    b_ld = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge fin_clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c, c1, c2, old_p, new_p, p1, p2, old_r;
    repeat (10) @(negedge fin_clk);
    check("R8 fb idle in reset", int'(s_fb), 0);
    check("R8 cmp idle in reset", int'(s_cmp), 0);
    check("R8 err low in reset", int'(s_err), 0);
    rst_n = 1'b1;

    s_wait_fb(c);
    s_wait_fb(c);
    check("R8 reset period small", c, 20);
    check("R8 err low after reset", int'(s_err), 0);
    old_p = 20;

    for (int n = 5; n <= 31; n++) begin
      for (int a = 0; a <= 3; a++) begin
        new_p = 4 * n + a;
        s_load(n, a, 5);
        s_wait_fb(c1);
        check("R6 period spanning write", c1 + 1, old_p);
        s_wait_fb(c2);
        check("R1 new period", c2, new_p);
        old_p = new_p;
      end
    end

    s_load(4, 0, 5);
    check("R5 err on small N", int'(s_err), 1);
    s_wait_fb(c1);
    check("R5 period after rejected N", c1 + 1, old_p);
    s_wait_fb(c2);
    check("R5 rejected N ignored", c2, old_p);
    s_load(6, 1, 4);
    check("R5 err on small R", int'(s_err), 1);
    s_wait_fb(c1);
    s_wait_fb(c2);
    check("R5 rejected R ignored", c2, old_p);
    s_load(5, 0, 5);
    check("R5 err cleared by legal write", int'(s_err), 0);

    old_r = 5;
    for (int r = 5; r <= 31; r++) begin
      s_wait_cmp(c);
      @(negedge fin_clk);
      s_load(5, 0, r);
      s_wait_cmp(c);
      s_wait_cmp(p1);
      total++;
      if (p1 != old_r && p1 != r) begin
        bad++;
        $display("FAIL R7 straddling period actual=%0d expected=%0d or %0d", p1, old_r, r);
      end
      s_wait_cmp(p2);
      check("R3 ref period", p2, r);
      old_r = r;
    end

    b_wait_fb(c);
    b_load(77, 5, 512);
    b_wait_fb(c1);
    check("R8 reset period full", c1 + 1, 320);
    b_wait_fb(c2);
    check("R2 ratio 4933", c2, 4933);
    b_wait_cmp(c);
    b_wait_cmp(p2);
    check("R3 ref 512", p2, 512);
    b_wait_cmp(p2);
    check("R3 ref 512 repeat", p2, 512);

    b_wait_fb(c);
    b_load(10, 20, 512);
    check("R4 err on A not below N", int'(b_err), 1);
    b_wait_fb(c1);
    check("R4 period after rejected A", c1 + 1, 4933);
    b_wait_fb(c2);
    check("R4 rejected A ignored", c2, 4933);

    finish_run();
  end
endmodule